// File: doc/BRIEF.md
# Late-Arrival Tolerant Pipeline Stage Register

This block sits between two pipeline stages. The designers can lower the supply until the slowest path into it sometimes misses the rising clock edge. A primary flop samples the stage input on the rising edge. A shadow latch stays open through the high phase of the clock and keeps watching the same input. It closes on the falling edge, so its contents are the value that really arrived.

At the falling edge the two copies are compared bit by bit. Any difference raises a one-bit error flag, and that flag is registered so that it holds for a full clock period. While the flag is set, the output takes the shadow copy instead of the primary copy. The downstream stage therefore still receives the right word, and pays for the late arrival out of its own slack. The high phase is assumed to be 2/5 of the period. Every path into the register must be longer than that window plus the latch hold time, or data of the following cycle would leak into the shadow. Meeting that minimum is the job of the surrounding netlist.

Top module: `spec_stage_reg`

## Requirements
- R1: When `din` is settled before the rising edge and does not change until after the falling edge, `dout` carries that value after the falling edge and `err` is 0.
- R2: The shadow copy follows `din` for the whole high phase and keeps the last high-phase value through the low phase.
- R3: After the falling edge, `err` is 1 exactly when the value of `din` at the falling edge differs from its value at the preceding rising edge.
- R4: While `err` is 1, `dout` equals the shadow copy, which is the value `din` held at the end of the high phase.
- R5: `err` changes only on a falling edge and holds its value across the following rising edge and high phase.
- R6: A change of `din` after the falling edge has no effect on `dout` or `err` in that cycle.
- R7: A synchronous reset (`rst` high at a rising edge) clears the primary copy, the shadow copy and `err`, so after the falling edge `dout` is 0 and `err` is 0.
- R8: A late change confined to any single bit, including bit 0 and bit W-1, sets `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stage clock, high phase is the shadow window |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W | Stage input from the combinational logic |
| dout | output | W | Corrected stage output, valid in the low phase |
| err | output | 1 | Late-arrival flag, registered on the falling edge |

## Verification
Detection and correction fall in the same cycle. The cycle in which the flag rises is also the cycle in which the output has to switch from the primary copy to the shadow copy. The bench sets up this case by driving one value before a rising edge and a different value a few nanoseconds into the high phase. It then checks that the low-phase output equals the second value while the flag is high. Changes placed just after the falling edge serve as the contrast case: in that cycle both the output and the flag must stay on the first value and on 0.

// File: rtl/spec_stage_reg.sv
module spec_stage_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         err
);

  logic [W-1:0] main_q;
  logic [W-1:0] shadow;
  logic [W-1:0] diff;
  logic         err_q;

  always_ff @(posedge clk) begin
    if (rst) main_q <= '0;
    else     main_q <= din;
  end

  always_latch begin
    if (clk) shadow = rst ? '0 : din;
  end

  assign diff = main_q ^ shadow;

  always_ff @(negedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |diff;
  end

  assign dout = err_q ? shadow : main_q;
  assign err  = err_q;

  // R1
  capture_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> main_q == $past(din));

  // R3
  flag_means_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> main_q != shadow);

  // R3
  clear_means_match_chk: assert property (@(posedge clk) disable iff (rst)
    !err_q |-> main_q == shadow);

  // R4
  output_is_shadow_chk: assert property (@(posedge clk) disable iff (rst)
    dout == shadow);

endmodule

// File: tb/spec_stage_reg_bench.sv
module spec_stage_reg_bench;
  localparam int W = 16;

  logic         clk;
  logic         rst;
  logic [W-1:0] din;
  logic [W-1:0] dout;
  logic         err;
  int checks;
  int errors;

  spec_stage_reg #(.W(W)) u_spec_stage_reg (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .err(err)
  );

  initial begin
    clk = 1'b0;
    forever begin
      #12 clk = 1'b1;
      #8  clk = 1'b0;
    end
  end

  task automatic check(input string req, input logic [W-1:0] got_d, input logic [W-1:0] exp_d,
                       input logic got_e, input logic exp_e);
    checks++;
    if (got_d !== exp_d || got_e !== exp_e) begin
      errors++;
      $display("FAIL %s dout=%h err=%b expected dout=%h err=%b", req, got_d, got_e, exp_d, exp_e);
    end
  endtask

  // starts and ends in the low phase
  task automatic stage(input string req, input logic [W-1:0] first, input logic [W-1:0] second,
                       input int dly);
    logic exp_e;
    din = first;
    @(posedge clk);
    if (dly < 8) begin
      #dly din = second;
      @(negedge clk);
      #2;
      exp_e = (first != second);
      check(req, dout, second, err, exp_e);
    end else begin
      @(negedge clk);
      #(dly - 8) din = second;
      #3;
      check(req, dout, first, err, 1'b0);
    end
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #2;
    check(req, dout, '0, err, 1'b0);
    rst = 1'b0;
  endtask

  task automatic flag_hold;
    stage("R5", 16'h1111, 16'h2222, 3);
    @(posedge clk);
    #4;
    checks++;
    if (err !== 1'b1) begin
      errors++;
      $display("FAIL R5 err=%b expected err=1 in high phase", err);
    end
    @(negedge clk);
    #2;
    check("R5", dout, 16'h2222, err, 1'b0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog dout=%h err=%b expected finish", dout, err);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst = 1'b1;
    din = 16'hdead;
    @(negedge clk);
    do_reset("R7");
    do_reset("R7");
    stage("R1", 16'h1234, 16'h1234, 3);
    stage("R1", 16'h0f0f, 16'h0f0f, 5);
    stage("R3 R4", 16'h00ff, 16'hff00, 2);
    stage("R2 R4", 16'haaaa, 16'h5555, 6);
    stage("R8 lsb", 16'h4000, 16'h4001, 4);
    stage("R8 msb", 16'h0001, 16'h8001, 7);
    stage("R3 same value", 16'h7777, 16'h7777, 1);
    stage("R6", 16'h3333, 16'hcccc, 9);
    stage("R6", 16'hcccc, 16'h0000, 10);
    flag_hold();
    stage("R3 R4", 16'hffff, 16'h0000, 3);
    do_reset("R7 after error");
    stage("R1 after reset", 16'hbeef, 16'hbeef, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule